// File: doc/BRIEF.md
# CAS-before-RAS Refresh Sequencer

This block keeps an asynchronous DRAM refreshed with CAS-before-RAS cycles. The row address comes from the device's internal counter, so the block needs no address path. It drives only the three strobes: row strobe, column strobe and write enable. Timing is expressed in whole clock cycles: how long the column strobe leads the row strobe, how long the row strobe stays low, and how long precharge lasts. All three are parameters.

Strobe ownership passes through a request/grant handshake with the access controller. The sequencer raises `req_o` and waits for `grant_i` before it drives any strobe low. It keeps `busy_o` high until the last precharge of its run is over. After reset it first issues a start-up burst of `INIT_CYCLES` refreshes and only then raises `init_done_o`. From that point an interval timer adds one owed refresh per `INTERVAL` cycles. Refreshes owed while the grant is withheld are counted in a saturating counter, and once the grant is given they are issued back to back.

Top module: `cbr_refresh_seq`

## Requirements
- R1: While reset is held and just after it, ras_n_o, cas_n_o and we_n_o are high, busy_o and init_done_o are low, pending_o is zero, and req_o is high because the start-up burst is owed.
- R2: No strobe goes low unless grant_i was high in the cycle before busy_o rose. While busy_o is low, ras_n_o and cas_n_o are both high, even with refreshes owed.
- R3: In each refresh, cas_n_o falls CSR_CYC cycles before ras_n_o falls and stays low for as long as ras_n_o is low.
- R4: ras_n_o stays low for exactly RAS_CYC cycles in each refresh.
- R5: Between two back-to-back refreshes, both strobes are high for RP_CYC cycles, and one refresh starts every CSR_CYC+RAS_CYC+RP_CYC cycles.
- R6: we_n_o stays high at all times.
- R7: After reset the block issues exactly INIT_CYCLES refreshes, back to back while grant is held. init_done_o rises in the cycle after the last precharge ends and stays high from then on.
- R8: Once init_done_o is high, the interval timer adds one to pending_o every INTERVAL cycles, and req_o is high whenever pending_o is nonzero or busy_o is high.
- R9: Owed refreshes build up in pending_o while grant is low. Once grant is given they run back to back, and each completed refresh lowers pending_o by one.
- R10: Dropping grant_i partway through a refresh does not cut it short. That refresh runs through its precharge, then busy_o falls and the rest stays owed.
- R11: pending_o saturates at 2^DEBT_W-1 and does not wrap on further timer ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant_i | input | 1 | Access side hands the strobes to the sequencer |
| req_o | output | 1 | Sequencer wants, or holds, the strobes |
| busy_o | output | 1 | Sequencer is driving the strobes |
| init_done_o | output | 1 | Start-up burst finished |
| pending_o | output | DEBT_W | Count of owed refreshes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, held high |

## Verification
The first run holds grant high all the way from reset. It shows the exact strobe waveform across the eight-cycle start-up burst and across the first timer-driven refresh. Grant is then held low for four timer intervals. That shows refresh debt building up, saturating, and leaving the strobes idle. Finally, grant is given and then pulled away during the second of three owed refreshes, which separates back-to-back issue from clean abandonment at a cycle boundary. A last grant clears the one refresh that is still owed.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_RASLO = 2'd2,
        ST_PRECH = 2'd3
    } cbr_state_e;
endpackage

// File: rtl/cbr_interval_timer.sv
module cbr_interval_timer #(
    parameter int INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int TW = $clog2(INTERVAL);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        tick_o = 1'b0;
        if (!en_i) begin
            r_d.cnt = TW'(INTERVAL - 1);
        end else if (r_q.cnt == '0) begin
            tick_o  = 1'b1;
            r_d.cnt = TW'(INTERVAL - 1);
        end else begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{cnt: TW'(INTERVAL - 1)};
        else        r_q <= r_d;
    end

    // checker: cycles elapsed since enable or since the previous tick
    logic [TW-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                gap_q <= '0;
        else if (!en_i || tick_o)  gap_q <= '0;
        else                       gap_q <= gap_q + 1'b1;
    end

    p_tick_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (gap_q == TW'(INTERVAL - 1)));
endmodule

// File: rtl/cbr_debt_counter.sv
module cbr_debt_counter #(
    parameter int DEBT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              dec_i,
    output logic [DEBT_W-1:0] pending_o
);
    localparam logic [DEBT_W-1:0] MAXV = {DEBT_W{1'b1}};

    typedef struct packed {
        logic [DEBT_W-1:0] cnt;
    } debt_t;

    debt_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case ({inc_i, dec_i})
            2'b10:   if (r_q.cnt != MAXV) r_d.cnt = r_q.cnt + 1'b1;
            2'b01:   if (r_q.cnt != '0)   r_d.cnt = r_q.cnt - 1'b1;
            default: r_d.cnt = r_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pending_o = r_q.cnt;

    p_debt_hold_at_max_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o == MAXV && inc_i && !dec_i) |=> (pending_o == MAXV));

    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (pending_o != '0));
endmodule

// File: rtl/cbr_strobe_fsm.sv
module cbr_strobe_fsm
    import cbr_pkg::*;
#(
    parameter int CSR_CYC     = 1,
    parameter int RAS_CYC     = 9,
    parameter int RP_CYC      = 5,
    parameter int INIT_CYCLES = 8,
    parameter int DEBT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant_i,
    input  logic              tick_i,
    input  logic [DEBT_W-1:0] pending_i,
    output logic              done_o,
    output logic              busy_o,
    output logic              init_done_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o
);
    localparam int MAXC = (RAS_CYC > CSR_CYC) ?
                          ((RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC) :
                          ((CSR_CYC > RP_CYC) ? CSR_CYC : RP_CYC);
    localparam int CW   = $clog2(MAXC + 1);
    localparam int IW   = $clog2(INIT_CYCLES + 1);

    typedef struct packed {
        cbr_state_e    state;
        logic [CW-1:0] cnt;
        logic [IW-1:0] init_cnt;
        logic          init_done;
    } fsm_t;

    fsm_t r_q, r_d;
    logic cycle_end;
    logic last_init;
    logic again;
    logic owed;

    always_comb begin
        r_d       = r_q;
        cycle_end = 1'b0;
        last_init = 1'b0;
        again     = 1'b0;
        owed      = !r_q.init_done || (pending_i != '0);
        unique case (r_q.state)
            ST_IDLE: begin
                if (grant_i && owed) begin
                    r_d.state = ST_SETUP;
                    r_d.cnt   = CW'(CSR_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (r_q.cnt == '0) begin
                    r_d.state = ST_RASLO;
                    r_d.cnt   = CW'(RAS_CYC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_RASLO: begin
                if (r_q.cnt == '0) begin
                    r_d.state = ST_PRECH;
                    r_d.cnt   = CW'(RP_CYC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_PRECH: begin
                if (r_q.cnt == '0) begin
                    cycle_end = 1'b1;
                    if (!r_q.init_done) begin
                        if (r_q.init_cnt == IW'(INIT_CYCLES - 1)) begin
                            last_init     = 1'b1;
                            r_d.init_done = 1'b1;
                        end else begin
                            r_d.init_cnt = r_q.init_cnt + 1'b1;
                        end
                        again = grant_i && !last_init;
                    end else begin
                        again = grant_i && ((pending_i > DEBT_W'(1)) || tick_i);
                    end
                    r_d.state = again ? ST_SETUP : ST_IDLE;
                    r_d.cnt   = CW'(CSR_CYC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, cnt: '0, init_cnt: '0, init_done: 1'b0};
        else        r_q <= r_d;
    end

    assign done_o      = cycle_end && r_q.init_done;
    assign busy_o      = (r_q.state != ST_IDLE);
    assign init_done_o = r_q.init_done;
    assign ras_n_o     = (r_q.state != ST_RASLO);
    assign cas_n_o     = !((r_q.state == ST_SETUP) || (r_q.state == ST_RASLO));
    assign we_n_o      = 1'b1;

    // checker-side run-length counters on the strobe pins
    logic [CW:0] lo_q, hi_q;
    logic        seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            seen_q <= 1'b0;
        end else begin
            lo_q <= !ras_n_o ? ((lo_q == (CW+1)'(MAXC)) ? lo_q : lo_q + 1'b1) : '0;
            hi_q <= ras_n_o  ? ((hi_q == (CW+1)'(RP_CYC)) ? hi_q : hi_q + 1'b1) : '0;
            if (!ras_n_o) seen_q <= 1'b1;
        end
    end

    p_cas_leads_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));

    p_cas_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n_o |-> !cas_n_o);

    p_ras_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o) |-> (lo_q == (CW+1)'(RAS_CYC)));

    p_precharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n_o) && seen_q) |-> (hi_q >= (CW+1)'(RP_CYC)));

    p_idle_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (ras_n_o && cas_n_o));

    p_start_needs_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(grant_i));

    p_init_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |=> init_done_o);
endmodule

// File: rtl/cbr_refresh_seq.sv
module cbr_refresh_seq #(
    parameter int CSR_CYC     = 1,
    parameter int RAS_CYC     = 9,
    parameter int RP_CYC      = 5,
    parameter int INIT_CYCLES = 8,
    parameter int INTERVAL    = 1560,
    parameter int DEBT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant_i,
    output logic              req_o,
    output logic              busy_o,
    output logic              init_done_o,
    output logic [DEBT_W-1:0] pending_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o
);
    logic tick;
    logic done;

    cbr_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (init_done_o),
        .tick_o (tick)
    );

    cbr_debt_counter #(.DEBT_W(DEBT_W)) u_debt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (tick),
        .dec_i     (done),
        .pending_o (pending_o)
    );

    cbr_strobe_fsm #(
        .CSR_CYC     (CSR_CYC),
        .RAS_CYC     (RAS_CYC),
        .RP_CYC      (RP_CYC),
        .INIT_CYCLES (INIT_CYCLES),
        .DEBT_W      (DEBT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_i     (grant_i),
        .tick_i      (tick),
        .pending_i   (pending_o),
        .done_o      (done),
        .busy_o      (busy_o),
        .init_done_o (init_done_o),
        .ras_n_o     (ras_n_o),
        .cas_n_o     (cas_n_o),
        .we_n_o      (we_n_o)
    );

    assign req_o = busy_o || !init_done_o || (pending_o != '0);

    p_req_covers_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> req_o);
endmodule

// File: tb/cbr_refresh_seq_test.sv
module cbr_refresh_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          grant_i = 1'b0;
    logic          req_o, busy_o, init_done_o, ras_n_o, cas_n_o, we_n_o;
    logic [DW-1:0] pending_o;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cbr_refresh_seq #(
        .CSR_CYC(1), .RAS_CYC(9), .RP_CYC(5),
        .INIT_CYCLES(8), .INTERVAL(100), .DEBT_W(DW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .grant_i(grant_i), .req_o(req_o),
        .busy_o(busy_o), .init_done_o(init_done_o), .pending_o(pending_o),
        .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o)
    );

    typedef struct packed {
        int       ofs;
        int       rq;
        logic     ras;
        logic     cas;
        logic     busy;
        logic     req;
        logic     idone;
        logic [1:0] pend;
    } vec_t;

    localparam int NV = 17;
    // offsets count clock edges after grant is first raised
    localparam vec_t VEC [NV] = '{
        '{0,   2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0}, // R2 idle until grant seen
        '{1,   3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0}, // R3 CAS first
        '{2,   3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0}, // R3 RAS follows
        '{10,  4, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0}, // R4 last RAS-low cycle
        '{11,  4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0}, // R4 RAS back up
        '{15,  5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0}, // R5 still precharging
        '{16,  5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0}, // R5 next cycle starts
        '{17,  7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0}, // R7 second refresh
        '{106, 7, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0}, // R7 eighth refresh
        '{120, 7, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0}, // R7 final precharge
        '{121, 7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0}, // R7 burst complete
        '{220, 8, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0}, // R8 before first tick
        '{221, 8, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'd1}, // R8 tick owes one
        '{222, 8, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1}, // R8 refresh begins
        '{223, 8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1}, // R8 RAS low
        '{236, 9, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1}, // R9 precharge
        '{237, 9, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0}  // R9 debt paid
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int falls;
        int fall1;
        int fall2;
        int lows;
        logic prev;
        int bad;

        // R1 reset state
        repeat (4) @(negedge clk);
        chk("R1 ras_n in reset", 32'(ras_n_o), 32'd1);
        chk("R1 cas_n in reset", 32'(cas_n_o), 32'd1);
        rst_n = 1'b1;
        step();
        chk("R1 we_n after reset", 32'(we_n_o), 32'd1);
        chk("R1 busy/init_done/pending after reset",
            {busy_o, init_done_o, 30'(pending_o)}, 32'd0);
        chk("R1 req after reset", 32'(req_o), 32'd1);
        step();
        chk("R2 no strobe without grant", {30'd0, ras_n_o, cas_n_o}, 32'd3);

        // vector walk: grant held from offset 0
        grant_i = 1'b1;
        for (int c = 0; c <= 240; c++) begin
            if (c > 0) step();
            chk("R6 we_n held high", 32'(we_n_o), 32'd1);
            for (int v = 0; v < NV; v++) begin
                if (VEC[v].ofs == c) begin
                    chk($sformatf("R%0d vec ofs %0d", VEC[v].rq, c),
                        {25'd0, VEC[v].ras, VEC[v].cas, VEC[v].busy, VEC[v].req,
                         VEC[v].idone, VEC[v].pend},
                        {25'd0, ras_n_o, cas_n_o, busy_o, req_o, init_done_o, pending_o});
                end
            end
        end

        // R9/R11: deferral with grant withheld for four intervals (ticks at 321,421,521,621)
        grant_i = 1'b0;
        bad = 0;
        for (int c = 241; c <= 640; c++) begin
            step();
            if (!ras_n_o || !cas_n_o || busy_o) bad++;
            if (c == 421) chk("R9 two refreshes owed", 32'(pending_o), 32'd2);
            if (c == 521) chk("R9 three refreshes owed", 32'(pending_o), 32'd3);
        end
        chk("R2 strobes idle while grant withheld", 32'(bad), 32'd0);
        chk("R11 pending saturated", 32'(pending_o), 32'd3);
        chk("R8 req while owed", 32'(req_o), 32'd1);

        // R9/R10: grant, then pull it during the second owed refresh
        grant_i = 1'b1;
        falls = 0; fall1 = -1; fall2 = -1; lows = 0; prev = ras_n_o;
        for (int g = 1; g <= 40; g++) begin
            step();
            if (prev && !ras_n_o) begin
                falls++;
                if (fall1 < 0) fall1 = g; else if (fall2 < 0) fall2 = g;
            end
            if (!ras_n_o) lows++;
            prev = ras_n_o;
            if (g == 20) grant_i = 1'b0;
            if (g == 30) chk("R10 refresh finishes after grant drop", 32'(busy_o), 32'd1);
            if (g == 31) begin
                chk("R10 busy falls at cycle boundary", 32'(busy_o), 32'd0);
                chk("R9 one refresh still owed", 32'(pending_o), 32'd1);
            end
        end
        chk("R9 two refreshes issued", 32'(falls), 32'd2);
        chk("R4 RAS-low total over two refreshes", 32'(lows), 32'd18);
        chk("R3 first RAS fall one cycle after CAS", 32'(fall1), 32'd2);
        chk("R5 back-to-back spacing", 32'(fall2 - fall1), 32'd15);

        // final grant clears the remaining debt
        grant_i = 1'b1;
        falls = 0; prev = ras_n_o;
        for (int g = 41; g <= 60; g++) begin
            step();
            if (prev && !ras_n_o) falls++;
            prev = ras_n_o;
            if (g == 55) chk("R10 busy through last precharge", 32'(busy_o), 32'd1);
        end
        chk("R9 last owed refresh issued", 32'(falls), 32'd1);
        chk("R9 debt cleared", {30'd0, pending_o}, 32'd0);
        chk("R8 req drops when clear", 32'(req_o), 32'd0);
        chk("R7 init_done stays high", 32'(init_done_o), 32'd1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule